// File: doc/BRIEF.md
# Option ROM Window Register and Address Decoder

This block is one configuration-space register of a bus device: the register that places the device's option ROM in memory. System software writes a base address and an enable into it. The block then compares every incoming bus address against that window and raises a hit when the address falls inside it.

The window size is fixed when the block is built. It is given as the parameter `ROM_BYTES`, which must be a power of two from 2 KB to 16 MB. Any other value stops elaboration. Software finds the size the usual way for a memory window: it writes all ones and reads the register back. Base bits that lie inside the window are wired to zero, so the value read back shows the size.

The register is 32 bits wide and is written through a configuration port with one byte enable per byte lane. Reads are combinational and need no wait states. Reset clears the whole register, so the ROM starts out disabled at base zero.

Top module: `optrom_window`

## Requirements
- R1: While reset is asserted, and after it is released, the register reads 0x00000000, and `rom_hit` stays low until software enables the window.
- R2: Bit 0 is the decode enable. It can be read and written through byte lane 0 (`cfg_be[0]`).
- R3: Bits 10 to 1 always read as zero. Writes to them, with any byte enables, change nothing.
- R4: Base bits from 11 up to log2(ROM_BYTES)-1 are hardwired to zero and read as zero whatever is written to them.
- R5: After all ones is written with all four byte enables set, the register reads ~(ROM_BYTES-1) | 1. With the default size of 64 KB this is 0xFFFF0001.
- R6: A write updates only the byte lanes whose enable bit is set. Bit i of `cfg_be` covers `cfg_wdata[8i+7:8i]`. No lane changes when `cfg_wr` is low.
- R7: When bit 0 is set, `rom_hit` is high in the same cycle exactly when `bus_addr[31:log2(ROM_BYTES)]` equals register bits [31:log2(ROM_BYTES)].
- R8: When bit 0 is clear, `rom_hit` is low for every address, including one that matches the stored base.
- R9: `cfg_rdata` always shows the current register value: the enable bit, the zero bits and the stored base bits. A write shows up on it in the cycle after the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe, taken at the rising clock edge |
| cfg_be | input | 4 | Byte enables for the write, one per byte lane |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Current register value, combinational read |
| bus_addr | input | 32 | Bus address to decode |
| rom_hit | output | 1 | High when `bus_addr` falls inside the enabled ROM window |

## Verification
The assertions assume that `cfg_wr`, `cfg_be` and `cfg_wdata` are stable at the sampling edge and are never unknown while reset is released. They also assume that `bus_addr` is always a known value, because the hit check compares it bit by bit. The bench changes every input only on the falling clock edge, drives all inputs to known values from time zero, and holds `cfg_wr` low whenever it only looks at reads or decode results. That way no write lands outside the cycle the bench intends.

// File: rtl/optrom_pkg.sv
package optrom_pkg;
   localparam int CFG_W    = 32;
   localparam int LANES    = CFG_W / 8;
   localparam int BASE_LSB = 11;          // lowest bit position that can hold base address
   localparam int MIN_LOG2 = 11;          // 2 KB
   localparam int MAX_LOG2 = 24;          // 16 MB

   function automatic bit size_ok(input longint unsigned bytes);
      return (bytes >= (64'd1 << MIN_LOG2)) && (bytes <= (64'd1 << MAX_LOG2)) &&
             ((bytes & (bytes - 1)) == 0);
   endfunction

   // bits software may change: enable bit plus base bits above the window size
   function automatic logic [CFG_W-1:0] writable_mask(input int log2_size);
      logic [CFG_W-1:0] m;
      m = '0;
      for (int b = 0; b < CFG_W; b++)
         if (b >= log2_size) m[b] = 1'b1;
      m[0] = 1'b1;
      return m;
   endfunction

   function automatic logic [CFG_W-1:0] window_mask(input int log2_size);
      logic [CFG_W-1:0] m;
      m = '0;
      for (int b = 0; b < CFG_W; b++)
         if (b >= log2_size) m[b] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/optrom_lane.sv
module optrom_lane #(
   parameter logic [7:0] LANE_MASK = 8'hFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wdata,
   output logic [7:0] q
);
   logic [7:0] q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_r <= '0;
      else if (wr_en)
         q_r <= (q_r & ~LANE_MASK) | (wdata & LANE_MASK);
   end

   assign q = q_r & LANE_MASK;
endmodule

// File: rtl/optrom_decode.sv
module optrom_decode #(
   parameter int ADDR_W = 32,
   parameter logic [ADDR_W-1:0] WIN_MASK = '1
) (
   input  logic              enable,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   logic same_window;

   assign same_window = ((addr ^ base) & WIN_MASK) == '0;
   assign hit         = enable & same_window;
endmodule

// File: rtl/optrom_window.sv
module optrom_window
   import optrom_pkg::*;
#(
   parameter longint unsigned ROM_BYTES = 64'd65536
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [LANES-1:0] cfg_be,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_rdata,
   input  logic [CFG_W-1:0] bus_addr,
   output logic             rom_hit
);
   localparam int SIZE_LOG2 = $clog2(ROM_BYTES);
   localparam logic [CFG_W-1:0] WR_MASK  = writable_mask(SIZE_LOG2);
   localparam logic [CFG_W-1:0] WIN_MASK = window_mask(SIZE_LOG2);

   generate
      if (!size_ok(ROM_BYTES)) begin : g_bad_size
         $error("optrom_window: ROM_BYTES must be a power of two from 2 KB to 16 MB");
      end
   endgenerate

   logic [CFG_W-1:0] reg_value;

   generate
      for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
         optrom_lane #(
            .LANE_MASK (WR_MASK[ln*8 +: 8])
         ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (cfg_wr & cfg_be[ln]),
            .wdata (cfg_wdata[ln*8 +: 8]),
            .q     (reg_value[ln*8 +: 8])
         );
      end
   endgenerate

   assign cfg_rdata = reg_value;

   optrom_decode #(
      .ADDR_W   (CFG_W),
      .WIN_MASK (WIN_MASK)
   ) u_decode (
      .enable (reg_value[0]),
      .base   (reg_value),
      .addr   (bus_addr),
      .hit    (rom_hit)
   );
endmodule

// File: rtl/optrom_window_chk.sv
module optrom_window_chk
   import optrom_pkg::*;
#(
   parameter longint unsigned ROM_BYTES = 64'd65536
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr,
   input logic [LANES-1:0] cfg_be,
   input logic [CFG_W-1:0] cfg_wdata,
   input logic [CFG_W-1:0] cfg_rdata,
   input logic [CFG_W-1:0] bus_addr,
   input logic             rom_hit
);
   localparam int LG = $clog2(ROM_BYTES);

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cfg_rdata == '0) && !rom_hit);  // R1

   AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_be[0]) |=> (cfg_rdata[0] == $past(cfg_wdata[0])));  // R2

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[10:1] == '0);  // R3

   AST_SIZE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[LG-1:1] == '0);  // R4

   AST_LANE3_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr && cfg_be[3]) |=> $stable(cfg_rdata[31:24]));  // R6

   AST_LANE2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr && cfg_be[2]) |=> $stable(cfg_rdata[23:16]));  // R6

   AST_HIT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[0] |-> (rom_hit == (bus_addr[31:LG] == cfg_rdata[31:LG])));  // R7

   AST_NO_HIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rdata[0] |-> !rom_hit);  // R8

   AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && (cfg_be == 4'hF)) |=> (cfg_rdata[31:LG] == $past(cfg_wdata[31:LG])));  // R9
endmodule

bind optrom_window optrom_window_chk #(.ROM_BYTES(ROM_BYTES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wr    (cfg_wr),
   .cfg_be    (cfg_be),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .bus_addr  (bus_addr),
   .rom_hit   (rom_hit)
);

// File: tb/optrom_window_tb_top.sv
module optrom_window_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [3:0]  cfg_be = 4'h0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] bus_addr = '0;
   logic [31:0] cfg_rdata;
   logic        rom_hit;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   optrom_window #(.ROM_BYTES(64'd65536)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .bus_addr(bus_addr), .rom_hit(rom_hit)
   );

   // {be, wdata, addr, expected rdata, expected hit}; 64 KB window, bits 31:16 are base
   localparam int NV = 11;
   localparam logic [100:0] VEC [NV] = '{
      {4'hF, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_0001, 1'b0},
      {4'hF, 32'hC000_0001, 32'hC000_1234, 32'hC000_0001, 1'b1},
      {4'h0, 32'hFFFF_FFFF, 32'hC000_FFFF, 32'hC000_0001, 1'b1},
      {4'h0, 32'h0000_0000, 32'hC001_0000, 32'hC000_0001, 1'b0},
      {4'h0, 32'h0000_0000, 32'hBFFF_FFFF, 32'hC000_0001, 1'b0},
      {4'h1, 32'h0000_07FE, 32'hC000_0000, 32'hC000_0000, 1'b0},
      {4'h1, 32'hFFFF_FFFF, 32'hC000_0000, 32'hC000_0001, 1'b1},
      {4'h2, 32'hFFFF_FFFF, 32'hC000_0000, 32'hC000_0001, 1'b1},
      {4'h4, 32'h00AB_0000, 32'hC0AB_8000, 32'hC0AB_0001, 1'b1},
      {4'h8, 32'h1200_0000, 32'hC0AB_0000, 32'h12AB_0001, 1'b0},
      {4'hF, 32'h12AB_0000, 32'h12AB_0000, 32'h12AB_0000, 1'b0}
   };
   string tags [NV] = '{"R5", "R7 R9", "R6 R7", "R7", "R7", "R3 R8",
                        "R2 R3", "R4", "R6 R7", "R6", "R8"};

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic write_then_look(input logic [3:0] be, input logic [31:0] wd,
                                  input logic [31:0] ad, input logic wr);
      @(negedge clk);
      cfg_wr = wr; cfg_be = be; cfg_wdata = wd;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_be = 4'h0; bus_addr = ad;
      #1;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #200000;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      // reset state, R1
      repeat (3) @(negedge clk);
      #1;
      check("R1 rdata in reset", cfg_rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check("R1 rdata after reset", cfg_rdata, 32'h0);
      check("R1 R8 no hit at base 0", {31'b0, rom_hit}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         write_then_look(VEC[i][100:97], VEC[i][96:65], VEC[i][64:33], 1'b1);
         check($sformatf("%s vec%0d rdata", tags[i], i), cfg_rdata, VEC[i][32:1]);
         check($sformatf("%s vec%0d hit", tags[i], i), {31'b0, rom_hit}, {31'b0, VEC[i][0]});
      end

      // R6: strobe low with all enables set changes nothing
      write_then_look(4'hF, 32'h5555_0001, 32'h12AB_0000, 1'b0);
      check("R6 no write without strobe", cfg_rdata, 32'h12AB_0000);

      // R9: enable on again, hit and readback show up after one edge
      write_then_look(4'h1, 32'h0000_0001, 32'h12AB_FFFE, 1'b1);
      check("R9 readback", cfg_rdata, 32'h12AB_0001);
      check("R7 hit at top of window", {31'b0, rom_hit}, 32'h1);

      // R1: reset in mid-run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 mid-run reset rdata", cfg_rdata, 32'h0);
      check("R1 mid-run reset hit", {31'b0, rom_hit}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      bus_addr = 32'h0000_0000;
      @(negedge clk); #1;
      check("R1 R8 disabled after reset", {31'b0, rom_hit}, 32'h0);

      finish_run();
   end
endmodule